// File: doc/BRIEF.md
# Network Interrupt Aggregator

This block gathers interrupt requests from the network sources of a system and presents them to the CPU as two 16-bit status words. Each source is named by a slot number and a port number. A slot-to-position table turns that pair into one status bit. Slot 0 owns the whole of the first word. Slots 1 to 4 each own one 4-bit nibble of the second word, in ascending order from the low nibble.

Status bits are active-low. A bit that reads 0 marks a pending source, and both words come out of reset as all ones. A raise strobe drives the addressed bit to 0 and a drop strobe returns it to 1. A single registered interrupt line is high while any bit of either word is 0.

The CPU reads the two status words through a small register port. Two general-purpose 16-bit mask words sit on the same port and can be read and written freely. The mask words do not gate the interrupt line.

Top module: `nirq_aggregator`

## Requirements
- R1: After reset both status words read 0xFFFF, both mask words read 0x0000, and `irq_o` is low.
- R2: A raise strobe for slot 0 and port p (0 to 15) drives bit p of status word 0 to 0 on the next clock edge.
- R3: A raise strobe for slot s (1 to 4) and port p (0 to 3) drives bit 4*(s-1)+p of status word 1 to 0 on the next clock edge.
- R4: A drop strobe for a mapped slot and port returns the addressed bit to 1 on the next clock edge. No status bit changes from 1 to 0 without a raise strobe, and no bit changes from 0 to 1 without a drop strobe.
- R5: When a raise strobe and a drop strobe arrive in the same cycle for the same bit, the bit ends up 0. When they arrive for different bits, both take effect.
- R6: `irq_o` goes high one clock edge after the status words first hold any 0 bit. It goes low one edge after both words return to 0xFFFF.
- R7: A read at address 0x20 returns status word 0 and a read at 0x22 returns status word 1. `rd_data_o` is registered on the edge where `rd_en_i` is high and shows the contents from just before that edge. A read at any other address outside the mask addresses returns 0x0000.
- R8: The mask words at addresses 0x2A and 0x2C keep the last value written and return it on read. Writing them has no effect on `irq_o` or on the status words.
- R9: Writes to addresses 0x20 and 0x22 are ignored. The status words change only through the strobes.
- R10: A strobe whose slot is 5 or higher is ignored. A strobe for slots 1 to 4 whose port is 4 or higher is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| set_vld_i | input | 1 | Raise strobe: marks a source pending |
| set_slot_i | input | 3 | Slot number for the raise strobe |
| set_port_i | input | 4 | Port number for the raise strobe |
| clr_vld_i | input | 1 | Drop strobe: marks a source idle |
| clr_slot_i | input | 3 | Slot number for the drop strobe |
| clr_port_i | input | 4 | Port number for the drop strobe |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | 8 | Register read byte address |
| wr_en_i | input | 1 | Register write request |
| wr_addr_i | input | 8 | Register write byte address |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt, high while any source is pending |

## Verification
A strobe lands in the status words on the first edge after it is driven. `irq_o` follows one edge later, so it reflects the strobes driven two cycles earlier. Read data is captured on the edge that sees `rd_en_i` and carries the status as it stood before that edge's strobes. The bench keeps a reference model of the status and mask words. It computes the expected read value from that model before applying the current cycle's strobes and writes. It delays the model's pending flag through a two-stage history, so each output is compared at the falling edge in the cycle where it is due.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

  // Number of status words produced by the slot map.
  localparam int NUM_BANKS = 2;

  // Read-mux selector for the register port.
  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_STAT0,
    RSEL_STAT1,
    RSEL_MASK_A,
    RSEL_MASK_B
  } rsel_e;

  // Slot 0 owns bank 0; every other slot lives in bank 1.
  function automatic int slot_bank(input int s);
    return (s == 0) ? 0 : 1;
  endfunction

  // Lowest bit index of a slot inside its bank.
  function automatic int slot_base(input int s, input int nib_w);
    return (s == 0) ? 0 : (s - 1) * nib_w;
  endfunction

  // Number of ports a slot may address.
  function automatic int slot_span(input int s, input int stat_w, input int nib_w);
    return (s == 0) ? stat_w : nib_w;
  endfunction

endpackage

// File: rtl/nirq_slot_decode.sv
module nirq_slot_decode import nirq_pkg::*; #(
  parameter int NUM_SLOTS = 5,
  parameter int STAT_W    = 16,
  parameter int NIB_W     = 4,
  parameter int SLOT_W    = 3,
  parameter int PORT_W    = 4
) (
  input  logic                              vld_i,
  input  logic [SLOT_W-1:0]                 slot_i,
  input  logic [PORT_W-1:0]                 port_i,
  output logic [NUM_BANKS-1:0][STAT_W-1:0]  hit_o
);

  localparam logic [STAT_W-1:0] ONE = STAT_W'(1);

  logic [NUM_BANKS-1:0][STAT_W-1:0] part [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int BANK = slot_bank(s);
    localparam int BASE = slot_base(s, NIB_W);
    localparam int SPAN = slot_span(s, STAT_W, NIB_W);

    logic              in_range;
    logic [STAT_W-1:0] vec;

    assign in_range = vld_i && (int'(slot_i) == s) && (int'(port_i) < SPAN);
    assign vec      = in_range ? (ONE << (BASE + int'(port_i))) : '0;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign part[s][b] = (b == BANK) ? vec : '0;
    end
  end

  always_comb begin
    hit_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      hit_o = hit_o | part[s];
    end
  end

endmodule

// File: rtl/nirq_status_bank.sv
module nirq_status_bank #(
  parameter int STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [STAT_W-1:0] set_hit_i,
  input  logic [STAT_W-1:0] clr_hit_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              pend_o
);

  // Active-low: the drop strobe returns a bit to 1, and the raise strobe
  // is applied last so that it wins a collision on the same bit.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stat_o <= '1;
    end else begin
      stat_o <= (stat_o | clr_hit_i) & ~set_hit_i;
    end
  end

  assign pend_o = ~&stat_o;

endmodule

// File: rtl/nirq_csr.sv
module nirq_csr import nirq_pkg::*; #(
  parameter int                STAT_W      = 16,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STAT0_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] STAT1_ADDR  = 8'h22,
  parameter logic [ADDR_W-1:0] MASKA_ADDR  = 8'h2A,
  parameter logic [ADDR_W-1:0] MASKB_ADDR  = 8'h2C
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic [STAT_W-1:0] stat0_i,
  input  logic [STAT_W-1:0] stat1_i,
  output logic [STAT_W-1:0] rd_data_o
);

  logic [STAT_W-1:0] mask_a_q;
  logic [STAT_W-1:0] mask_b_q;
  rsel_e             rd_sel;
  rsel_e             wr_sel;
  logic [STAT_W-1:0] rd_mux;

  function automatic rsel_e decode(input logic [ADDR_W-1:0] a);
    if (a == STAT0_ADDR) return RSEL_STAT0;
    if (a == STAT1_ADDR) return RSEL_STAT1;
    if (a == MASKA_ADDR) return RSEL_MASK_A;
    if (a == MASKB_ADDR) return RSEL_MASK_B;
    return RSEL_NONE;
  endfunction

  assign rd_sel = decode(rd_addr_i);
  assign wr_sel = decode(wr_addr_i);

  // Only the mask words accept writes; status addresses fall through.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_a_q <= '0;
      mask_b_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel == RSEL_MASK_A) mask_a_q <= wr_data_i;
      if (wr_sel == RSEL_MASK_B) mask_b_q <= wr_data_i;
    end
  end

  always_comb begin
    unique case (rd_sel)
      RSEL_STAT0:  rd_mux = stat0_i;
      RSEL_STAT1:  rd_mux = stat1_i;
      RSEL_MASK_A: rd_mux = mask_a_q;
      RSEL_MASK_B: rd_mux = mask_b_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      rd_data_o <= rd_mux;
    end
  end

endmodule

// File: rtl/nirq_aggregator.sv
module nirq_aggregator import nirq_pkg::*; #(
  parameter int                NUM_SLOTS  = 5,
  parameter int                STAT_W     = 16,
  parameter int                NIB_W      = 4,
  parameter int                SLOT_W     = 3,
  parameter int                PORT_W     = 4,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STAT0_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] STAT1_ADDR = 8'h22,
  parameter logic [ADDR_W-1:0] MASKA_ADDR = 8'h2A,
  parameter logic [ADDR_W-1:0] MASKB_ADDR = 8'h2C
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              set_vld_i,
  input  logic [SLOT_W-1:0] set_slot_i,
  input  logic [PORT_W-1:0] set_port_i,
  input  logic              clr_vld_i,
  input  logic [SLOT_W-1:0] clr_slot_i,
  input  logic [PORT_W-1:0] clr_port_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              irq_o
);

  logic [NUM_BANKS-1:0][STAT_W-1:0] set_hit;
  logic [NUM_BANKS-1:0][STAT_W-1:0] clr_hit;
  logic [NUM_BANKS-1:0][STAT_W-1:0] stat_q;
  logic [NUM_BANKS-1:0]             bank_pend;
  logic                             any_pend;
  logic                             irq_q;

  nirq_slot_decode #(
    .NUM_SLOTS(NUM_SLOTS), .STAT_W(STAT_W), .NIB_W(NIB_W),
    .SLOT_W(SLOT_W), .PORT_W(PORT_W)
  ) u_set_dec (
    .vld_i (set_vld_i),
    .slot_i(set_slot_i),
    .port_i(set_port_i),
    .hit_o (set_hit)
  );

  nirq_slot_decode #(
    .NUM_SLOTS(NUM_SLOTS), .STAT_W(STAT_W), .NIB_W(NIB_W),
    .SLOT_W(SLOT_W), .PORT_W(PORT_W)
  ) u_clr_dec (
    .vld_i (clr_vld_i),
    .slot_i(clr_slot_i),
    .port_i(clr_port_i),
    .hit_o (clr_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    nirq_status_bank #(.STAT_W(STAT_W)) u_bank (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .set_hit_i(set_hit[b]),
      .clr_hit_i(clr_hit[b]),
      .stat_o   (stat_q[b]),
      .pend_o   (bank_pend[b])
    );
  end

  assign any_pend = |bank_pend;

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= any_pend;
  end

  assign irq_o = irq_q;

  nirq_csr #(
    .STAT_W(STAT_W), .ADDR_W(ADDR_W),
    .STAT0_ADDR(STAT0_ADDR), .STAT1_ADDR(STAT1_ADDR),
    .MASKA_ADDR(MASKA_ADDR), .MASKB_ADDR(MASKB_ADDR)
  ) u_csr (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .stat0_i  (stat_q[0]),
    .stat1_i  (stat_q[1]),
    .rd_data_o(rd_data_o)
  );

endmodule

// File: rtl/nirq_checker.sv
module nirq_checker #(
  parameter int                NUM_SLOTS  = 5,
  parameter int                STAT_W     = 16,
  parameter int                SLOT_W     = 3,
  parameter int                PORT_W     = 4,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STAT0_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] STAT1_ADDR = 8'h22,
  parameter logic [ADDR_W-1:0] MASKA_ADDR = 8'h2A,
  parameter logic [ADDR_W-1:0] MASKB_ADDR = 8'h2C
) (
  input logic              clk,
  input logic              rst,
  input logic              set_vld,
  input logic [SLOT_W-1:0] set_slot,
  input logic [PORT_W-1:0] set_port,
  input logic              clr_vld,
  input logic [SLOT_W-1:0] clr_slot,
  input logic [PORT_W-1:0] clr_port,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [STAT_W-1:0] rd_data,
  input logic [STAT_W-1:0] stat0,
  input logic [STAT_W-1:0] stat1,
  input logic              irq
);

  logic pending;
  assign pending = (stat0 != '1) || (stat1 != '1);

  // R2: a bit may fall to 0 only after a raise strobe
  p_fall_needs_set_r2: assert property (@(posedge clk) disable iff (rst)
    !set_vld |=> ((($past(stat0) & ~stat0) == '0) && (($past(stat1) & ~stat1) == '0)));

  // R4: a bit may rise to 1 only after a drop strobe
  p_rise_needs_clr_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_vld |=> (((~$past(stat0) & stat0) == '0) && ((~$past(stat1) & stat1) == '0)));

  // R5: raise beats drop on the same slot-0 bit
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (set_vld && clr_vld && set_slot == '0 && clr_slot == '0 && set_port == clr_port)
    |=> (stat0[$past(set_port)] == 1'b0));

  // R6: the interrupt line follows the pending state one edge later
  p_irq_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(pending)));

  // R7: unmapped read addresses return zero
  p_unmapped_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != STAT0_ADDR && rd_addr != STAT1_ADDR &&
     rd_addr != MASKA_ADDR && rd_addr != MASKB_ADDR) |=> (rd_data == '0));

  // R9: register writes alone never move the status words
  p_status_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !set_vld && !clr_vld) |=> ($stable(stat0) && $stable(stat1)));

  // R10: strobes naming a slot beyond the table leave status unchanged
  p_bad_slot_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (set_vld && int'(set_slot) >= NUM_SLOTS && !clr_vld) |=> ($stable(stat0) && $stable(stat1)));

endmodule

bind nirq_aggregator nirq_checker #(
  .NUM_SLOTS(NUM_SLOTS), .STAT_W(STAT_W), .SLOT_W(SLOT_W), .PORT_W(PORT_W),
  .ADDR_W(ADDR_W), .STAT0_ADDR(STAT0_ADDR), .STAT1_ADDR(STAT1_ADDR),
  .MASKA_ADDR(MASKA_ADDR), .MASKB_ADDR(MASKB_ADDR)
) u_chk (
  .clk     (clk_i),
  .rst     (rst_i),
  .set_vld (set_vld_i),
  .set_slot(set_slot_i),
  .set_port(set_port_i),
  .clr_vld (clr_vld_i),
  .clr_slot(clr_slot_i),
  .clr_port(clr_port_i),
  .rd_en   (rd_en_i),
  .rd_addr (rd_addr_i),
  .wr_en   (wr_en_i),
  .rd_data (rd_data_o),
  .stat0   (stat_q[0]),
  .stat1   (stat_q[1]),
  .irq     (irq_o)
);

// File: tb/nirq_aggregator_tb.sv
module nirq_aggregator_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_vld = 1'b0;
  logic [2:0]  set_slot = '0;
  logic [3:0]  set_port = '0;
  logic        clr_vld = 1'b0;
  logic [2:0]  clr_slot = '0;
  logic [3:0]  clr_port = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;

  // reference model
  logic [15:0] m0 = 16'hFFFF, m1 = 16'hFFFF, mk_a = 16'h0, mk_b = 16'h0;
  logic        pend_h1 = 1'b0, pend_h2 = 1'b0;
  logic        rd_pend = 1'b0;
  logic [15:0] rd_exp = '0;
  string       rd_tag = "";

  always #2 clk = ~clk;

  nirq_aggregator u_dut (
    .clk_i(clk), .rst_i(rst),
    .set_vld_i(set_vld), .set_slot_i(set_slot), .set_port_i(set_port),
    .clr_vld_i(clr_vld), .clr_slot_i(clr_slot), .clr_port_i(clr_port),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  // {bank1 mask, bank0 mask} for one strobe, per R2, R3, R10
  function automatic logic [31:0] strobe_mask(input logic v, input logic [2:0] s, input logic [3:0] p);
    logic [31:0] r = '0;
    if (v) begin
      if (s == 3'd0) r[int'(p)] = 1'b1;
      else if (s <= 3'd4 && p < 4'd4) r[16 + 4*(int'(s)-1) + int'(p)] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] a);
    case (a)
      8'h20: return m0;
      8'h22: return m1;
      8'h2A: return mk_a;
      8'h2C: return mk_b;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic step(input logic sv, input logic [2:0] ss, input logic [3:0] sp,
                      input logic cv, input logic [2:0] cs, input logic [3:0] cp,
                      input logic re, input logic [7:0] ra,
                      input logic we, input logic [7:0] wa, input logic [15:0] wd,
                      input string tag);
    logic [31:0] sm, cm;
    @(negedge clk);
    check("R6 irq", {15'd0, irq}, {15'd0, pend_h2});
    if (rd_pend) check(rd_tag, rd_data, rd_exp);
    rd_pend = re;
    if (re) begin rd_exp = exp_read(ra); rd_tag = tag; end
    set_vld = sv; set_slot = ss; set_port = sp;
    clr_vld = cv; clr_slot = cs; clr_port = cp;
    rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
    sm = strobe_mask(sv, ss, sp);
    cm = strobe_mask(cv, cs, cp);
    m0 = (m0 | cm[15:0]) & ~sm[15:0];
    m1 = (m1 | cm[31:16]) & ~sm[31:16];
    if (we && wa == 8'h2A) mk_a = wd;
    if (we && wa == 8'h2C) mk_b = wd;
    pend_h2 = pend_h1;
    pend_h1 = (m0 != 16'hFFFF) || (m1 != 16'hFFFF);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, a, 0, 0, 0, tag);
  endtask
  task automatic raise(input logic [2:0] s, input logic [3:0] p);
    step(1, s, p, 0, 0, 0, 0, 0, 0, 0, 0, "raise");
  endtask
  task automatic drop(input logic [2:0] s, input logic [3:0] p);
    step(0, 0, 0, 1, s, p, 0, 0, 0, 0, 0, "drop");
  endtask
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, a, d, "write");
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {15'd0, irq}, 16'h0000);
    rd(8'h20, "R1 stat0"); rd(8'h22, "R1 stat1");
    rd(8'h2A, "R1 mask_a"); rd(8'h2C, "R1 mask_b");

    raise(0, 3); rd(8'h20, "R2 slot0 port3");
    raise(0, 15); rd(8'h20, "R2 slot0 port15");
    raise(2, 1); rd(8'h22, "R3 slot2 port1");
    raise(4, 3); rd(8'h22, "R3 slot4 port3");
    raise(1, 0); rd(8'h22, "R3 slot1 port0");
    drop(0, 3); rd(8'h20, "R4 drop slot0 port3");
    drop(4, 3); rd(8'h22, "R4 drop slot4 port3");

    step(1, 3, 2, 1, 3, 2, 0, 0, 0, 0, 0, "collide");
    rd(8'h22, "R5 same bit raise wins");
    step(1, 0, 7, 1, 3, 2, 0, 0, 0, 0, 0, "mixed");
    rd(8'h20, "R5 different bits raise");
    rd(8'h22, "R5 different bits drop");

    wr(8'h20, 16'h0000); wr(8'h22, 16'hFFFF);
    rd(8'h20, "R9 stat0 unwritable"); rd(8'h22, "R9 stat1 unwritable");

    wr(8'h2A, 16'h1234); wr(8'h2C, 16'hBEEF);
    rd(8'h2A, "R8 mask_a"); rd(8'h2C, "R8 mask_b");

    raise(5, 0); raise(7, 1); raise(1, 4); raise(4, 15);
    rd(8'h20, "R10 stat0 untouched"); rd(8'h22, "R10 stat1 untouched");
    rd(8'h24, "R7 unmapped"); rd(8'h00, "R7 unmapped zero");

    for (int p = 0; p < 16; p++) drop(0, 4'(p));
    for (int s = 1; s <= 4; s++)
      for (int p = 0; p < 4; p++) drop(3'(s), 4'(p));
    idle(); idle();
    check("R6 irq low when idle", {15'd0, irq}, 16'h0000);
    rd(8'h20, "R6 stat0 all ones");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ra, wa;
      logic [7:0] pick [5];
      pick[0] = 8'h20; pick[1] = 8'h22; pick[2] = 8'h2A; pick[3] = 8'h2C;
      pick[4] = 8'($urandom);
      ra = pick[$urandom % 5];
      wa = pick[$urandom % 5];
      step(($urandom % 4) == 0, 3'($urandom), 4'($urandom),
           ($urandom % 2) == 0, 3'($urandom), 4'($urandom),
           ($urandom % 3) == 0, ra,
           ($urandom % 8) == 0, wa, 16'($urandom), "R7 random read");
    end
    idle(); idle(); idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule